// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs trap entry for a small 32-bit in-order core. Each cycle it looks at four request lines: an external interrupt, a hardware break, a hardware exception and a memory-management fault. It also reads the core's architectural state: the current program counter, the machine status word, the exception status word, the three instruction-state flags (delay slot, immediate prefix, branch-immediate) and the pending branch target. When it accepts a request, the next cycle carries a complete entry frame. The frame holds the handler address, the link register index and the return value to write there, the new status word, an optional exception status word, an optional branch-target save, and strobes that clear the instruction-state flags and the load reservation. The core applies the frame in that cycle.

The return address saved for a memory-management fault is rewound so that the handler can restart the interrupted instruction sequence. For a fault in a delay slot it points back at the branch, or at the prefix in front of the branch. For a fault after a lone immediate prefix it points at the prefix. The fault also produces a syndrome code that depends on the kind of fault and the kind of access.

A small state machine sequences entries. It has three states. ST_RUN accepts requests. ST_MMU_SETTLE is a one-cycle window after a fault entry, during which nothing is accepted. ST_HALT is a sticky fatal state that is entered if a fault request is still present during the settle window. The transitions are:
- ST_RUN→ST_MMU_SETTLE when a fault entry is taken.
- ST_MMU_SETTLE→ST_RUN when the settle cycle passes with no fault request.
- ST_MMU_SETTLE→ST_HALT when a fault request is present during the settle cycle.
- ST_HALT holds until reset.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset `ent_valid`, `flags_clr`, `resv_clr` and `fatal` are all 0, and no entry appears without a request.
- R2: A request sampled on a clock edge in ST_RUN gives `ent_valid`=1 for the following cycle. `ent_cause` is coded 0 interrupt, 1 break, 2 hardware exception, 3 memory fault. `nxt_pc` is `cfg_base` plus 0x10 for an interrupt, plus 0x18 for a break, and plus 0x20 for both a hardware exception and a memory fault.
- R3: Interrupt entry writes the current PC to link register 14 and clears the interrupt-enable bit (status bit 1).
- R4: An interrupt is accepted only when status bit 1 (enable) is 1, status bit 9 (exception in progress) and status bit 3 (break in progress) are both 0, and neither `flag_ds` nor `flag_imm` is set. Otherwise the interrupt gives no entry.
- R5: Break entry writes the current PC to link register 16 and sets status bit 3.
- R6: Hardware exception entry writes PC+4 to link register 17, sets status bit 9 and writes an exception status word equal to `cur_esr` with bit 12 replaced by `flag_ds`.
- R7: While `cfg_exc_en` is 0 a hardware exception request gives no entry, and any lower-priority request pending with it is handled as if the exception request were absent.
- R8: Memory fault entry sets status bit 9 and writes link register 17. The value written is PC−8 if `flag_ds` and `flag_bimm` are both set, PC−4 if only `flag_ds` is set, PC−4 if only `flag_imm` is set, and PC otherwise.
- R9: The memory fault status word is 16 for a data protection fault, 17 for a fetch protection fault, 18 for a data miss and 19 for a fetch miss. Bit 10 is added for a store, and bit 12 is set when `flag_ds` is set. `mmu_acc` is coded 0 load, 1 store, 2 fetch, and `mmu_miss`=1 marks a miss.
- R10: For hardware exception and memory fault entries, `btr_we` equals `flag_ds`, and when it is set `btr_val` equals `br_target`. Interrupt and break entries assert neither `esr_we` nor `btr_we`.
- R11: On every entry, user-mode bit 11 is copied to bit 12 and virtual-mode bit 13 is copied to bit 14. Bits 11 and 13 are then cleared. All other status bits pass through unchanged apart from the cause-specific bit.
- R12: `flags_clr` and `resv_clr` are high exactly in the cycles where `ent_valid` is high.
- R13: When several requests are eligible together, exactly one is taken. Priority from highest to lowest is memory fault, hardware exception, break, interrupt.
- R14: In the cycle after a memory fault is sampled (ST_MMU_SETTLE), no request is accepted. A fault request sampled in that cycle raises `fatal`. `fatal` then stays high until reset, and no further entries are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 32 | Vector table base address |
| cfg_exc_en | input | 1 | Hardware exception support enabled |
| req_irq | input | 1 | External interrupt request |
| req_brk | input | 1 | Hardware break request |
| req_hwexc | input | 1 | Hardware exception request |
| req_mmu | input | 1 | Memory-management fault request |
| mmu_miss | input | 1 | Fault kind: 1 miss, 0 protection |
| mmu_acc | input | 2 | Faulting access: 0 load, 1 store, 2 fetch |
| cur_pc | input | 32 | Current program counter |
| cur_msr | input | 32 | Current machine status word |
| cur_esr | input | 32 | Current exception status word |
| flag_ds | input | 1 | Instruction is in a delay slot |
| flag_imm | input | 1 | Immediate prefix is active |
| flag_bimm | input | 1 | Branch was preceded by an immediate prefix |
| br_target | input | 32 | Pending branch target |
| ent_valid | output | 1 | Entry frame valid this cycle |
| ent_cause | output | 2 | Cause of the entry |
| nxt_pc | output | 32 | Handler address |
| lnk_idx | output | 5 | Link register index |
| lnk_val | output | 32 | Return address to write |
| nxt_msr | output | 32 | New machine status word |
| esr_we | output | 1 | Exception status word write enable |
| nxt_esr | output | 32 | New exception status word |
| btr_we | output | 1 | Branch target save enable |
| btr_val | output | 32 | Branch target to save |
| flags_clr | output | 1 | Clear instruction-state flags |
| resv_clr | output | 1 | Invalidate the load reservation |
| fatal | output | 1 | Sticky fatal nested-fault indication |

## Verification
The hardest situation to reach is the settle window after a fault entry. Reaching it needs a fault request accepted on one edge, followed on the very next edge by either a second fault request (the fatal path) or a lower-priority request that must be held off for exactly one cycle. The stimulus creates both cases. It raises a break request in the cycle the fault frame appears and keeps it up for two edges, so the break is refused in ST_MMU_SETTLE and taken afterwards. It holds a fault request across two edges to enter ST_HALT, then shows that later requests produce nothing. Interrupt gating is covered by sweeping each status bit and flag that blocks acceptance, one at a time.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int XLEN    = 32;
    localparam int RIDX_W  = 5;
    localparam int NCAUSE  = 4;

    // status word bit positions (saved copies sit one above the live bits)
    localparam int MSR_IE  = 1;
    localparam int MSR_BIP = 3;
    localparam int MSR_EIP = 9;
    localparam int MSR_UM  = 11;
    localparam int MSR_UMS = 12;
    localparam int MSR_VM  = 13;
    localparam int MSR_VMS = 14;

    // exception status word bit positions
    localparam int ESR_DS    = 12;
    localparam int ESR_STORE = 10;

    // link register indices per cause
    localparam logic [RIDX_W-1:0] LNK_IRQ = RIDX_W'(14);
    localparam logic [RIDX_W-1:0] LNK_BRK = RIDX_W'(16);
    localparam logic [RIDX_W-1:0] LNK_EXC = RIDX_W'(17);

    // encoding doubles as priority: larger value wins
    typedef enum logic [1:0] {
        CAUSE_IRQ   = 2'd0,
        CAUSE_BRK   = 2'd1,
        CAUSE_HWEXC = 2'd2,
        CAUSE_MMU   = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        ST_RUN        = 2'd0,
        ST_MMU_SETTLE = 2'd1,
        ST_HALT       = 2'd2
    } ctl_state_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef struct packed {
        cause_e              cause;
        logic [XLEN-1:0]     pc;
        logic [RIDX_W-1:0]   lidx;
        logic [XLEN-1:0]     lval;
        logic [XLEN-1:0]     msr;
        logic                esr_we;
        logic [XLEN-1:0]     esr;
        logic                btr_we;
        logic [XLEN-1:0]     btr;
    } frame_t;

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
(
    input  logic   allow,
    input  logic   cfg_exc_en,
    input  logic   req_irq,
    input  logic   req_brk,
    input  logic   req_hwexc,
    input  logic   req_mmu,
    input  logic   st_ie,
    input  logic   st_eip,
    input  logic   st_bip,
    input  logic   flag_ds,
    input  logic   flag_imm,
    output logic   take,
    output cause_e cause
);

    logic [NCAUSE-1:0] live;

    always_comb begin
        live              = '0;
        live[CAUSE_IRQ]   = req_irq & st_ie & ~st_eip & ~st_bip
                            & ~flag_ds & ~flag_imm;
        live[CAUSE_BRK]   = req_brk;
        live[CAUSE_HWEXC] = req_hwexc & cfg_exc_en;
        live[CAUSE_MMU]   = req_mmu;
    end

    // later (higher-valued) causes override earlier ones
    always_comb begin
        take  = allow & (|live);
        cause = CAUSE_IRQ;
        for (int i = 0; i < NCAUSE; i++) begin
            if (live[i]) cause = cause_e'(i[1:0]);
        end
    end

endmodule

// File: rtl/trap_frame_calc.sv
module trap_frame_calc
    import trap_pkg::*;
#(
    parameter logic [XLEN-1:0] OFS_IRQ = 32'h10,
    parameter logic [XLEN-1:0] OFS_BRK = 32'h18,
    parameter logic [XLEN-1:0] OFS_EXC = 32'h20
)(
    input  cause_e          cause,
    input  logic [XLEN-1:0] cfg_base,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] cur_msr,
    input  logic [XLEN-1:0] cur_esr,
    input  logic            flag_ds,
    input  logic            flag_imm,
    input  logic            flag_bimm,
    input  logic [XLEN-1:0] br_target,
    input  logic            mmu_miss,
    input  logic [1:0]      mmu_acc,
    output frame_t          frm
);

    localparam logic [XLEN-1:0] STEP  = XLEN'(4);
    localparam logic [XLEN-1:0] STEP2 = XLEN'(8);
    localparam logic [XLEN-1:0] SYN_BASE = XLEN'(16);

    logic [XLEN-1:0] rewind_pc;
    logic [XLEN-1:0] syndrome;
    logic            is_fetch;
    logic            is_store;
    logic [XLEN-1:0] msr_w;

    assign is_fetch = (mmu_acc == ACC_FETCH);
    assign is_store = (mmu_acc == ACC_STORE);

    // restart point for a faulting access
    always_comb begin
        if (flag_ds)
            rewind_pc = flag_bimm ? (cur_pc - STEP2) : (cur_pc - STEP);
        else if (flag_imm)
            rewind_pc = cur_pc - STEP;
        else
            rewind_pc = cur_pc;
    end

    always_comb begin
        syndrome           = SYN_BASE;
        syndrome[1]        = mmu_miss;
        syndrome[0]        = is_fetch;
        syndrome[ESR_STORE] = is_store;
        syndrome[ESR_DS]   = flag_ds;
    end

    always_comb begin
        msr_w      = cur_msr;
        frm.cause  = cause;
        frm.pc     = cfg_base + OFS_EXC;
        frm.lidx   = LNK_EXC;
        frm.lval   = cur_pc;
        frm.esr_we = 1'b0;
        frm.esr    = '0;
        frm.btr_we = 1'b0;
        frm.btr    = '0;
        unique case (cause)
            CAUSE_IRQ: begin
                msr_w[MSR_IE] = 1'b0;
                frm.pc        = cfg_base + OFS_IRQ;
                frm.lidx      = LNK_IRQ;
                frm.lval      = cur_pc;
            end
            CAUSE_BRK: begin
                msr_w[MSR_BIP] = 1'b1;
                frm.pc         = cfg_base + OFS_BRK;
                frm.lidx       = LNK_BRK;
                frm.lval       = cur_pc;
            end
            CAUSE_HWEXC: begin
                msr_w[MSR_EIP]   = 1'b1;
                frm.lval         = cur_pc + STEP;
                frm.esr_we       = 1'b1;
                frm.esr          = cur_esr;
                frm.esr[ESR_DS]  = flag_ds;
                frm.btr_we       = flag_ds;
                frm.btr          = flag_ds ? br_target : '0;
            end
            CAUSE_MMU: begin
                msr_w[MSR_EIP] = 1'b1;
                frm.lval       = rewind_pc;
                frm.esr_we     = 1'b1;
                frm.esr        = syndrome;
                frm.btr_we     = flag_ds;
                frm.btr        = flag_ds ? br_target : '0;
            end
        endcase
        // save the mode bits into their shadow copies, then drop them
        msr_w[MSR_UMS] = msr_w[MSR_UM];
        msr_w[MSR_VMS] = msr_w[MSR_VM];
        msr_w[MSR_UM]  = 1'b0;
        msr_w[MSR_VM]  = 1'b0;
        frm.msr        = msr_w;
    end

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter logic [XLEN-1:0] OFS_IRQ = 32'h10,
    parameter logic [XLEN-1:0] OFS_BRK = 32'h18,
    parameter logic [XLEN-1:0] OFS_EXC = 32'h20
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   cfg_base,
    input  logic              cfg_exc_en,
    input  logic              req_irq,
    input  logic              req_brk,
    input  logic              req_hwexc,
    input  logic              req_mmu,
    input  logic              mmu_miss,
    input  logic [1:0]        mmu_acc,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   cur_msr,
    input  logic [XLEN-1:0]   cur_esr,
    input  logic              flag_ds,
    input  logic              flag_imm,
    input  logic              flag_bimm,
    input  logic [XLEN-1:0]   br_target,
    output logic              ent_valid,
    output logic [1:0]        ent_cause,
    output logic [XLEN-1:0]   nxt_pc,
    output logic [RIDX_W-1:0] lnk_idx,
    output logic [XLEN-1:0]   lnk_val,
    output logic [XLEN-1:0]   nxt_msr,
    output logic              esr_we,
    output logic [XLEN-1:0]   nxt_esr,
    output logic              btr_we,
    output logic [XLEN-1:0]   btr_val,
    output logic              flags_clr,
    output logic              resv_clr,
    output logic              fatal
);

    ctl_state_e state_q, state_d;
    logic       take;
    cause_e     win;
    frame_t     frm;
    frame_t     frame_q;
    logic       valid_q;

    trap_arbiter u_arb (
        .allow      (state_q == ST_RUN),
        .cfg_exc_en (cfg_exc_en),
        .req_irq    (req_irq),
        .req_brk    (req_brk),
        .req_hwexc  (req_hwexc),
        .req_mmu    (req_mmu),
        .st_ie      (cur_msr[MSR_IE]),
        .st_eip     (cur_msr[MSR_EIP]),
        .st_bip     (cur_msr[MSR_BIP]),
        .flag_ds    (flag_ds),
        .flag_imm   (flag_imm),
        .take       (take),
        .cause      (win)
    );

    trap_frame_calc #(
        .OFS_IRQ (OFS_IRQ),
        .OFS_BRK (OFS_BRK),
        .OFS_EXC (OFS_EXC)
    ) u_calc (
        .cause     (win),
        .cfg_base  (cfg_base),
        .cur_pc    (cur_pc),
        .cur_msr   (cur_msr),
        .cur_esr   (cur_esr),
        .flag_ds   (flag_ds),
        .flag_imm  (flag_imm),
        .flag_bimm (flag_bimm),
        .br_target (br_target),
        .mmu_miss  (mmu_miss),
        .mmu_acc   (mmu_acc),
        .frm       (frm)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:        if (take && win == CAUSE_MMU) state_d = ST_MMU_SETTLE;
            ST_MMU_SETTLE: state_d = req_mmu ? ST_HALT : ST_RUN;
            ST_HALT:       state_d = ST_HALT;
            default:       state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // entry frame register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            frame_q <= '0;
        end else begin
            valid_q <= take;
            if (take) frame_q <= frm;
        end
    end

    assign ent_valid = valid_q;
    assign ent_cause = frame_q.cause;
    assign nxt_pc    = frame_q.pc;
    assign lnk_idx   = frame_q.lidx;
    assign lnk_val   = frame_q.lval;
    assign nxt_msr   = frame_q.msr;
    assign esr_we    = valid_q & frame_q.esr_we;
    assign nxt_esr   = frame_q.esr;
    assign btr_we    = valid_q & frame_q.btr_we;
    assign btr_val   = frame_q.btr;
    assign flags_clr = valid_q;
    assign resv_clr  = valid_q;
    assign fatal     = (state_q == ST_HALT);

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
    import trap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [XLEN-1:0]   cfg_base,
    input logic              cfg_exc_en,
    input logic              req_mmu,
    input logic [XLEN-1:0]   cur_pc,
    input logic [XLEN-1:0]   cur_msr,
    input logic              flag_ds,
    input logic              flag_imm,
    input logic              ent_valid,
    input logic [1:0]        ent_cause,
    input logic [XLEN-1:0]   nxt_pc,
    input logic [RIDX_W-1:0] lnk_idx,
    input logic [XLEN-1:0]   lnk_val,
    input logic [XLEN-1:0]   nxt_msr,
    input logic              esr_we,
    input logic [XLEN-1:0]   nxt_esr,
    input logic              btr_we,
    input logic              fatal
);

    // R3
    irq_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid && ent_cause == 2'd0 |->
            nxt_pc == $past(cfg_base) + 32'h10 && lnk_idx == 5'd14 &&
            lnk_val == $past(cur_pc) && !nxt_msr[MSR_IE]);

    // R4
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid && ent_cause == 2'd0 |->
            $past(cur_msr[MSR_IE]) && !$past(cur_msr[MSR_EIP]) &&
            !$past(cur_msr[MSR_BIP]) && !$past(flag_ds) && !$past(flag_imm));

    // R7
    exc_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid && ent_cause == 2'd2 |-> $past(cfg_exc_en));

    // R10
    ds_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid && ent_cause[1] |->
            esr_we && nxt_esr[ESR_DS] == $past(flag_ds) && btr_we == $past(flag_ds));

    // R11
    mode_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |-> !nxt_msr[MSR_UM] && !nxt_msr[MSR_VM] &&
            nxt_msr[MSR_UMS] == $past(cur_msr[MSR_UM]) &&
            nxt_msr[MSR_VMS] == $past(cur_msr[MSR_VM]));

    // R13
    mmu_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |-> (ent_cause == 2'd3) == $past(req_mmu));

    // R14
    settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid && ent_cause == 2'd3 |=> !ent_valid);

    // R14
    fatal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> fatal && !ent_valid);

endmodule

bind trap_entry_ctrl trap_entry_chk u_trap_entry_chk (.*);

// File: tb/test_trap_entry_ctrl.sv
`timescale 1ns/1ps
module test_trap_entry_ctrl;

    typedef struct {
        int          cause;
        logic [31:0] pc;
        int          lidx;
        logic [31:0] lval;
        logic [31:0] msr;
        bit          esr_we;
        logic [31:0] esr;
        bit          btr_we;
        logic [31:0] btr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_base = 32'h0000_4000;
    logic        cfg_exc_en = 1'b1;
    logic        req_irq = 0, req_brk = 0, req_hwexc = 0, req_mmu = 0;
    logic        mmu_miss = 0;
    logic [1:0]  mmu_acc = 2'd0;
    logic [31:0] cur_pc = 32'h0000_1000;
    logic [31:0] cur_msr = 32'h0;
    logic [31:0] cur_esr = 32'h0;
    logic        flag_ds = 0, flag_imm = 0, flag_bimm = 0;
    logic [31:0] br_target = 32'h0000_2000;

    logic        ent_valid;
    logic [1:0]  ent_cause;
    logic [31:0] nxt_pc, lnk_val, nxt_msr, nxt_esr, btr_val;
    logic [4:0]  lnk_idx;
    logic        esr_we, btr_we, flags_clr, resv_clr, fatal;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 0;
    exp_t sbq[$];

    always #10 clk = ~clk;

    trap_entry_ctrl i_trap_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_exc_en(cfg_exc_en),
        .req_irq(req_irq), .req_brk(req_brk), .req_hwexc(req_hwexc), .req_mmu(req_mmu),
        .mmu_miss(mmu_miss), .mmu_acc(mmu_acc), .cur_pc(cur_pc), .cur_msr(cur_msr),
        .cur_esr(cur_esr), .flag_ds(flag_ds), .flag_imm(flag_imm), .flag_bimm(flag_bimm),
        .br_target(br_target), .ent_valid(ent_valid), .ent_cause(ent_cause),
        .nxt_pc(nxt_pc), .lnk_idx(lnk_idx), .lnk_val(lnk_val), .nxt_msr(nxt_msr),
        .esr_we(esr_we), .nxt_esr(nxt_esr), .btr_we(btr_we), .btr_val(btr_val),
        .flags_clr(flags_clr), .resv_clr(resv_clr), .fatal(fatal)
    );

    task automatic chk(input bit ok, input string req, input string detail);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: %s", req, detail);
        end
    endtask

    // expected frame from the requirement text
    function automatic exp_t model(input int c, input string tag);
        exp_t e;
        logic [31:0] m = cur_msr;
        e.cause = c; e.tag = tag;
        e.esr_we = 0; e.esr = 0; e.btr_we = 0; e.btr = 0;
        e.pc = cfg_base + 32'h20; e.lidx = 17; e.lval = cur_pc;
        case (c)
            0: begin m[1] = 0; e.pc = cfg_base + 32'h10; e.lidx = 14; end
            1: begin m[3] = 1; e.pc = cfg_base + 32'h18; e.lidx = 16; end
            2: begin
                m[9] = 1; e.lval = cur_pc + 4; e.esr_we = 1;
                e.esr = cur_esr; e.esr[12] = flag_ds;
                e.btr_we = flag_ds; e.btr = br_target;
            end
            default: begin
                m[9] = 1;
                if (flag_ds) e.lval = flag_bimm ? cur_pc - 8 : cur_pc - 4;
                else if (flag_imm) e.lval = cur_pc - 4;
                e.esr_we = 1;
                e.esr = (mmu_acc == 2'd2) ? (mmu_miss ? 32'd19 : 32'd17)
                                          : (mmu_miss ? 32'd18 : 32'd16);
                if (mmu_acc == 2'd1) e.esr = e.esr | 32'd1024;
                if (flag_ds) e.esr = e.esr | 32'h1000;
                e.btr_we = flag_ds; e.btr = br_target;
            end
        endcase
        m[12] = m[11]; m[14] = m[13]; m[11] = 0; m[13] = 0;
        e.msr = m;
        return e;
    endfunction

    function automatic int winner(input bit irq, input bit brk, input bit hx, input bit mm);
        if (mm) return 3;
        if (hx && cfg_exc_en) return 2;
        if (brk) return 1;
        if (irq && cur_msr[1] && !cur_msr[3] && !cur_msr[9] && !flag_ds && !flag_imm) return 0;
        return -1;
    endfunction

    // driver: one request cycle plus one idle cycle
    task automatic fire(input bit irq, input bit brk, input bit hx, input bit mm, input string tag);
        int c;
        @(negedge clk);
        req_irq = irq; req_brk = brk; req_hwexc = hx; req_mmu = mm;
        c = winner(irq, brk, hx, mm);
        if (c >= 0) sbq.push_back(model(c, tag));
        @(negedge clk);
        req_irq = 0; req_brk = 0; req_hwexc = 0; req_mmu = 0;
        if (c < 0)
            chk(ent_valid == 1'b0, tag, $sformatf("ent_valid got %0b exp 0", ent_valid));
        @(negedge clk);
    endtask

    // monitor: compare each produced frame against the scoreboard
    always @(negedge clk) begin
        if (rst_n && ent_valid) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R13", $sformatf("unexpected entry cause %0d exp none", ent_cause));
            end else begin
                exp_t e;
                bit ok;
                e = sbq.pop_front();
                ok = (ent_cause == e.cause[1:0]) && (nxt_pc == e.pc) &&
                     (lnk_idx == e.lidx[4:0]) && (lnk_val == e.lval) &&
                     (nxt_msr == e.msr) && (esr_we == e.esr_we) &&
                     (btr_we == e.btr_we) &&
                     (!e.esr_we || nxt_esr == e.esr) &&
                     (!e.btr_we || btr_val == e.btr);
                chk(ok, e.tag, $sformatf(
                    "got c=%0d pc=%h l=%0d lv=%h msr=%h ew=%0b esr=%h bw=%0b btr=%h exp c=%0d pc=%h l=%0d lv=%h msr=%h ew=%0b esr=%h bw=%0b btr=%h",
                    ent_cause, nxt_pc, lnk_idx, lnk_val, nxt_msr, esr_we, nxt_esr, btr_we, btr_val,
                    e.cause, e.pc, e.lidx, e.lval, e.msr, e.esr_we, e.esr, e.btr_we, e.btr));
                chk(flags_clr && resv_clr, "R12",
                    $sformatf("flags_clr=%0b resv_clr=%0b exp 1 1", flags_clr, resv_clr));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: run did not finish, got hung exp done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!ent_valid && !fatal && !flags_clr && !resv_clr, "R1",
            $sformatf("v=%0b f=%0b fc=%0b rc=%0b exp 0", ent_valid, fatal, flags_clr, resv_clr));
        fire(0, 0, 0, 0, "R1 idle");

        // R2 R3 R11: interrupt with VM set
        cur_msr = 32'h0000_2002;
        fire(1, 0, 0, 0, "R3 irq vm");
        cur_msr = 32'h0000_0802; cur_pc = 32'h0000_1234;
        fire(1, 0, 0, 0, "R11 irq um");

        // R4 gating, one blocker at a time
        cur_msr = 32'h0000_0000; fire(1, 0, 0, 0, "R4 ie off");
        cur_msr = 32'h0000_0202; fire(1, 0, 0, 0, "R4 eip");
        cur_msr = 32'h0000_000A; fire(1, 0, 0, 0, "R4 bip");
        cur_msr = 32'h0000_0002; flag_ds = 1; fire(1, 0, 0, 0, "R4 ds");
        flag_ds = 0; flag_imm = 1; fire(1, 0, 0, 0, "R4 imm");
        flag_imm = 0;

        // R5 break, both modes set
        cur_msr = 32'h0000_2802;
        fire(0, 1, 0, 0, "R5 brk");

        // R6 R10 hardware exception
        cur_esr = 32'h0000_1055;
        fire(0, 0, 1, 0, "R6 hwexc");
        flag_ds = 1; br_target = 32'h0000_5678;
        fire(0, 0, 1, 0, "R10 hwexc ds");
        flag_ds = 0;

        // R7 exception support off
        cfg_exc_en = 0;
        fire(0, 0, 1, 0, "R7 off");
        fire(0, 1, 1, 0, "R7 brk passes");
        cfg_exc_en = 1;

        // R9 syndromes
        cur_pc = 32'h0000_3000;
        mmu_acc = 2'd0; mmu_miss = 0; fire(0, 0, 0, 1, "R9 load prot");
        mmu_acc = 2'd2; mmu_miss = 0; fire(0, 0, 0, 1, "R9 fetch prot");
        mmu_acc = 2'd0; mmu_miss = 1; fire(0, 0, 0, 1, "R9 load miss");
        mmu_acc = 2'd2; mmu_miss = 1; fire(0, 0, 0, 1, "R9 fetch miss");
        mmu_acc = 2'd1; mmu_miss = 1; fire(0, 0, 0, 1, "R9 store miss");
        mmu_acc = 2'd1; mmu_miss = 0; fire(0, 0, 0, 1, "R9 store prot");

        // R8 rewind cases
        mmu_acc = 2'd0; mmu_miss = 1;
        flag_ds = 1; flag_bimm = 1; fire(0, 0, 0, 1, "R8 ds bimm");
        flag_bimm = 0;              fire(0, 0, 0, 1, "R8 ds");
        flag_ds = 0; flag_imm = 1;  fire(0, 0, 0, 1, "R8 imm");
        flag_imm = 0;

        // R13 priority
        cur_msr = 32'h0000_0002;
        fire(1, 1, 1, 1, "R13 all");
        fire(1, 1, 1, 0, "R13 no mmu");
        fire(1, 1, 0, 0, "R13 brk irq");

        // R14 settle window holds off a break for one edge
        @(negedge clk);
        req_mmu = 1;
        sbq.push_back(model(3, "R14 mmu"));
        sbq.push_back(model(1, "R14 brk after settle"));
        @(negedge clk);
        req_mmu = 0; req_brk = 1;
        @(negedge clk);
        chk(ent_valid == 1'b0, "R14", $sformatf("settle ent_valid got %0b exp 0", ent_valid));
        @(negedge clk);
        req_brk = 0;
        @(negedge clk);

        // R14 fatal: fault request held across the settle edge
        req_mmu = 1;
        sbq.push_back(model(3, "R14 mmu fatal"));
        @(negedge clk);
        @(negedge clk);
        req_mmu = 0;
        chk(fatal == 1'b1, "R14", $sformatf("fatal got %0b exp 1", fatal));
        req_brk = 1; req_irq = 1;
        repeat (3) @(negedge clk);
        chk(fatal == 1'b1 && ent_valid == 1'b0, "R14",
            $sformatf("halted fatal=%0b ent_valid=%0b exp 1 0", fatal, ent_valid));
        req_brk = 0; req_irq = 0;
        @(negedge clk);
        chk(sbq.size() == 0, "R2", $sformatf("pending frames got %0d exp 0", sbq.size()));

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule